// File: doc/BRIEF.md
# Paged DMA Transfer Address Generator

This block produces the physical bus address of each transfer on one DMA channel and keeps the channel's remaining unit count. A 16-bit current address runs inside a fixed page. The page comes from an 8-bit page register that supplies bits 23:16 and, when `HI_PAGE_EN` is set, from a high page register that supplies bits 31:24. Byte channels address 64 KB pages. Word channels shift the current address left by one, so they address 128 KB pages, and in that case the low bit of the page register is not used.

Loading the channel copies the base address and base count into the current registers and makes the channel active. Each accepted step strobe moves the address by one unit, up or down according to the direction input, and lowers the count by one. Address stepping never carries into the page. A terminal count occurs when the count passes from zero to all ones, so a programmed count of N moves N+1 units. On a terminal count the block raises a one-cycle pulse. It then does one of two things. With auto-initialise on, it reloads the current registers from the base registers and stays active. With auto-initialise off, it masks itself and reports a latched terminal-count status. Steps are ignored while the controller is disabled and while the channel is masked.

The control state machine has three states: `CH_IDLE` (masked, no terminal count seen), `CH_RUN` (active) and `CH_DONE` (masked after a terminal count). It has these transitions: `T_ARM` (a load moves any state to `CH_RUN`), `T_TERM` (a terminal count without auto-initialise moves `CH_RUN` to `CH_DONE`), `T_RELOAD` (a terminal count with auto-initialise keeps `CH_RUN`) and `T_STEP` (a non-terminal step keeps `CH_RUN`). Every other case holds the state.

Top module: `dma_page_addr_gen`

## Requirements
- R1: After reset the channel is masked (`masked`=1), `tc_status`=0, `tc_pulse`=0, and `cur_addr` and `cur_count` are 0.
- R2: A `load` in any state makes `cur_addr`=`base_addr`, `cur_count`=`base_count`, `masked`=0 and `tc_status`=0 at the next edge. `load` takes priority over `step`.
- R3: With `word_mode`=0 the bus address is {`hi_page`, `page`, `cur_addr`}, that is, bits 31:24 = `hi_page`, bits 23:16 = `page` and bits 15:0 = `cur_addr`.
- R4: With `word_mode`=1 the bus address is {`hi_page`, `page[7:1]`, `cur_addr`, 0}. Bit 0 of `page` has no effect on the address.
- R5: With `dec_mode`=0 each accepted step adds 1 to `cur_addr`. 0xFFFF wraps to 0x0000 and the page bits of the bus address stay unchanged.
- R6: With `dec_mode`=1 each accepted step subtracts 1 from `cur_addr`. 0x0000 wraps to 0xFFFF.
- R7: Each accepted step lowers `cur_count` by 1. A step taken at count 0 is the terminal count. `tc_pulse` is 1 in the cycle after that step and 0 in all other cycles.
- R8: On a terminal count with `auto_init`=0, the step still updates the address and sets the count to 0xFFFF. The channel becomes masked with `tc_status`=1, and later steps leave `cur_addr` and `cur_count` unchanged until the next `load`.
- R9: On a terminal count with `auto_init`=1, `cur_addr` and `cur_count` are reloaded from `base_addr` and `base_count`, the channel stays unmasked and `tc_status` stays 0.
- R10: While `ctrl_en`=0 no step is accepted, and `cur_addr` and `cur_count` hold.
- R11: Steps given before the first `load` are ignored (the channel is masked from reset).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_en | input | 1 | Controller enable; 0 blocks all steps |
| load | input | 1 | Arm channel: copy base registers into current registers |
| base_addr | input | 16 | Base address register value |
| base_count | input | 16 | Base count register value |
| page | input | 8 | Page register (bus address bits 23:16) |
| hi_page | input | 8 | High page register (bus address bits 31:24) |
| word_mode | input | 1 | 1 = word channel (address shifted left by one) |
| dec_mode | input | 1 | 1 = address decrements, 0 = increments |
| auto_init | input | 1 | 1 = reload from base on terminal count |
| step | input | 1 | One transfer unit completed |
| bus_addr | output | 32 | Physical address of the current transfer |
| cur_addr | output | 16 | Current address register |
| cur_count | output | 16 | Current count register |
| tc_pulse | output | 1 | One-cycle terminal count pulse |
| tc_status | output | 1 | Latched terminal count status |
| masked | output | 1 | Channel is masked (steps ignored) |

## Verification
A wrong state or a wrong counter shows up one cycle after the step that caused it. A wrong address register makes `cur_addr` and `bus_addr` wrong at the next edge, and every later address stays off by the same amount until the channel is loaded again. A count that is off by one makes the terminal count pulse arrive one step early or late. The same error also moves the masking, or the reload in auto-initialise mode, by one step. A state machine stuck in the wrong state shows at once on `masked` and `tc_status`, and steps that should be frozen go on changing `cur_addr`.

// File: rtl/dma_page_pkg.sv
package dma_page_pkg;

    typedef enum logic [1:0] {
        CH_IDLE = 2'd0,
        CH_RUN  = 2'd1,
        CH_DONE = 2'd2
    } chan_state_e;

endpackage

// File: rtl/dma_chan_fsm.sv
module dma_chan_fsm
    import dma_page_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  logic        step_ok,
    input  logic        count_zero,
    input  logic        auto_init,
    output logic        accept,
    output logic        tc_event,
    output logic        reload,
    output logic        masked,
    output logic        tc_status
);

    chan_state_e state_q;
    chan_state_e state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CH_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d  = state_q;
        accept   = 1'b0;
        tc_event = 1'b0;
        reload   = 1'b0;
        unique case (state_q)
            CH_IDLE: begin
                if (load) state_d = CH_RUN;            // T_ARM
            end
            CH_RUN: begin
                if (load) begin
                    state_d = CH_RUN;                  // T_ARM
                end else if (step_ok) begin
                    accept = 1'b1;
                    if (count_zero) begin
                        tc_event = 1'b1;
                        if (auto_init) begin
                            reload  = 1'b1;
                            state_d = CH_RUN;          // T_RELOAD
                        end else begin
                            state_d = CH_DONE;         // T_TERM
                        end
                    end else begin
                        state_d = CH_RUN;              // T_STEP
                    end
                end
            end
            CH_DONE: begin
                if (load) state_d = CH_RUN;            // T_ARM
            end
            default: state_d = CH_IDLE;
        endcase
    end

    assign masked    = (state_q != CH_RUN);
    assign tc_status = (state_q == CH_DONE);

endmodule

// File: rtl/dma_step_unit.sv
module dma_step_unit #(
    parameter int ADDR_W  = 16,
    parameter int COUNT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               accept,
    input  logic               reload,
    input  logic               tc_event,
    input  logic               dec_mode,
    input  logic [ADDR_W-1:0]  base_addr,
    input  logic [COUNT_W-1:0] base_count,
    output logic [ADDR_W-1:0]  cur_addr,
    output logic [COUNT_W-1:0] cur_count,
    output logic               count_zero,
    output logic               tc_pulse
);

    localparam logic [ADDR_W-1:0]  ADDR_ONE  = ADDR_W'(1);
    localparam logic [COUNT_W-1:0] COUNT_ONE = COUNT_W'(1);

    logic [ADDR_W-1:0] addr_next;

    // stepping is confined to the address width: no carry into the page
    assign addr_next  = dec_mode ? (cur_addr - ADDR_ONE) : (cur_addr + ADDR_ONE);
    assign count_zero = (cur_count == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr  <= '0;
            cur_count <= '0;
            tc_pulse  <= 1'b0;
        end else begin
            tc_pulse <= tc_event;
            if (load || reload) begin
                cur_addr  <= base_addr;
                cur_count <= base_count;
            end else if (accept) begin
                cur_addr  <= addr_next;
                cur_count <= cur_count - COUNT_ONE;
            end
        end
    end

endmodule

// File: rtl/dma_addr_compose.sv
module dma_addr_compose #(
    parameter int ADDR_W     = 16,
    parameter int PAGE_W     = 8,
    parameter bit HI_PAGE_EN = 1'b1
) (
    input  logic [ADDR_W-1:0]          cur_addr,
    input  logic [PAGE_W-1:0]          page,
    input  logic [PAGE_W-1:0]          hi_page,
    input  logic                       word_mode,
    output logic [ADDR_W+2*PAGE_W-1:0] bus_addr
);

    localparam int LOW_W = ADDR_W + PAGE_W;

    logic [LOW_W-1:0] low_part;

    // word channels drop page bit 0; address bit 16 comes from the shift
    always_comb begin
        if (word_mode) begin
            low_part = {page[PAGE_W-1:1], cur_addr, 1'b0};
        end else begin
            low_part = {page, cur_addr};
        end
    end

    generate
        if (HI_PAGE_EN) begin : g_hi
            assign bus_addr = {hi_page, low_part};
        end else begin : g_no_hi
            logic unused_hi;
            assign unused_hi = ^hi_page;
            assign bus_addr  = {{PAGE_W{1'b0}}, low_part};
        end
    endgenerate

endmodule

// File: rtl/dma_page_addr_gen.sv
module dma_page_addr_gen #(
    parameter int ADDR_W     = 16,
    parameter int COUNT_W    = 16,
    parameter int PAGE_W     = 8,
    parameter bit HI_PAGE_EN = 1'b1,
    localparam int BUS_W     = ADDR_W + 2 * PAGE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctrl_en,
    input  logic               load,
    input  logic [ADDR_W-1:0]  base_addr,
    input  logic [COUNT_W-1:0] base_count,
    input  logic [PAGE_W-1:0]  page,
    input  logic [PAGE_W-1:0]  hi_page,
    input  logic               word_mode,
    input  logic               dec_mode,
    input  logic               auto_init,
    input  logic               step,
    output logic [BUS_W-1:0]   bus_addr,
    output logic [ADDR_W-1:0]  cur_addr,
    output logic [COUNT_W-1:0] cur_count,
    output logic               tc_pulse,
    output logic               tc_status,
    output logic               masked
);

    logic accept;
    logic tc_event;
    logic reload;
    logic count_zero;

    dma_chan_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .step_ok    (step && ctrl_en),
        .count_zero (count_zero),
        .auto_init  (auto_init),
        .accept     (accept),
        .tc_event   (tc_event),
        .reload     (reload),
        .masked     (masked),
        .tc_status  (tc_status)
    );

    dma_step_unit #(
        .ADDR_W  (ADDR_W),
        .COUNT_W (COUNT_W)
    ) u_step (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .accept     (accept),
        .reload     (reload),
        .tc_event   (tc_event),
        .dec_mode   (dec_mode),
        .base_addr  (base_addr),
        .base_count (base_count),
        .cur_addr   (cur_addr),
        .cur_count  (cur_count),
        .count_zero (count_zero),
        .tc_pulse   (tc_pulse)
    );

    dma_addr_compose #(
        .ADDR_W     (ADDR_W),
        .PAGE_W     (PAGE_W),
        .HI_PAGE_EN (HI_PAGE_EN)
    ) u_compose (
        .cur_addr  (cur_addr),
        .page      (page),
        .hi_page   (hi_page),
        .word_mode (word_mode),
        .bus_addr  (bus_addr)
    );

endmodule

// File: rtl/dma_page_addr_chk.sv
module dma_page_addr_chk #(
    parameter int ADDR_W  = 16,
    parameter int COUNT_W = 16,
    parameter int PAGE_W  = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       ctrl_en,
    input logic                       load,
    input logic [ADDR_W-1:0]          base_addr,
    input logic [COUNT_W-1:0]         base_count,
    input logic [PAGE_W-1:0]          page,
    input logic                       word_mode,
    input logic                       dec_mode,
    input logic                       auto_init,
    input logic                       step,
    input logic [ADDR_W+2*PAGE_W-1:0] bus_addr,
    input logic [ADDR_W-1:0]          cur_addr,
    input logic [COUNT_W-1:0]         cur_count,
    input logic                       tc_pulse,
    input logic                       tc_status,
    input logic                       masked
);

    logic taken;
    assign taken = step && ctrl_en && !masked && !load;

    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cur_addr == $past(base_addr)) && (cur_count == $past(base_count))
                 && !masked && !tc_status);

    p_byte_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !word_mode |-> (bus_addr[ADDR_W+PAGE_W-1:0] == {page, cur_addr}));

    p_word_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        word_mode |-> (bus_addr[0] == 1'b0) && (bus_addr[ADDR_W:1] == cur_addr));

    p_inc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && !dec_mode && !(auto_init && cur_count == '0))
        |=> cur_addr == $past(cur_addr) + ADDR_W'(1));

    p_dec_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && dec_mode && !(auto_init && cur_count == '0))
        |=> cur_addr == $past(cur_addr) - ADDR_W'(1));

    p_tc_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && cur_count == '0) |=> tc_pulse);

    p_no_stray_tc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(taken && cur_count == '0) |=> !tc_pulse);

    p_term_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && cur_count == '0 && !auto_init) |=> masked && tc_status);

    p_masked_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (masked && !load) |=> $stable(cur_addr) && $stable(cur_count));

    p_reload_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && cur_count == '0 && auto_init)
        |=> (cur_addr == $past(base_addr)) && (cur_count == $past(base_count)) && !masked);

    p_disabled_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_en && !load) |=> $stable(cur_addr) && $stable(cur_count));

endmodule

bind dma_page_addr_gen dma_page_addr_chk #(
    .ADDR_W  (ADDR_W),
    .COUNT_W (COUNT_W),
    .PAGE_W  (PAGE_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_en    (ctrl_en),
    .load       (load),
    .base_addr  (base_addr),
    .base_count (base_count),
    .page       (page),
    .word_mode  (word_mode),
    .dec_mode   (dec_mode),
    .auto_init  (auto_init),
    .step       (step),
    .bus_addr   (bus_addr),
    .cur_addr   (cur_addr),
    .cur_count  (cur_count),
    .tc_pulse   (tc_pulse),
    .tc_status  (tc_status),
    .masked     (masked)
);

// File: tb/dma_page_addr_gen_tb.sv
`timescale 1ns/1ps
module dma_page_addr_gen_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_en = 1'b1;
    logic        load = 1'b0;
    logic [15:0] base_addr = '0;
    logic [15:0] base_count = '0;
    logic [7:0]  page = '0;
    logic [7:0]  hi_page = '0;
    logic        word_mode = 1'b0;
    logic        dec_mode = 1'b0;
    logic        auto_init = 1'b0;
    logic        step = 1'b0;
    logic [31:0] bus_addr;
    logic [15:0] cur_addr;
    logic [15:0] cur_count;
    logic        tc_pulse;
    logic        tc_status;
    logic        masked;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    dma_page_addr_gen u_dut (
        .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en), .load(load),
        .base_addr(base_addr), .base_count(base_count), .page(page),
        .hi_page(hi_page), .word_mode(word_mode), .dec_mode(dec_mode),
        .auto_init(auto_init), .step(step), .bus_addr(bus_addr),
        .cur_addr(cur_addr), .cur_count(cur_count), .tc_pulse(tc_pulse),
        .tc_status(tc_status), .masked(masked)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_load(input logic [15:0] a, input logic [15:0] c);
        base_addr = a;
        base_count = c;
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
    endtask

    task automatic do_steps(input int n);
        for (int i = 0; i < n; i++) begin
            step = 1'b1;
            @(negedge clk);
        end
        step = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 masked", 32'(masked), 32'd1);
        check("R1 tc_status", 32'(tc_status), 32'd0);
        check("R1 tc_pulse", 32'(tc_pulse), 32'd0);
        check("R1 cur_addr", 32'(cur_addr), 32'd0);
        check("R1 cur_count", 32'(cur_count), 32'd0);
        page = 8'h12; hi_page = 8'hAB;
        #1;
        check("R3 bus at reset", bus_addr, 32'hAB12_0000);
    endtask

    task automatic t_idle_ignored;
        do_steps(3);
        check("R11 addr", 32'(cur_addr), 32'd0);
        check("R11 count", 32'(cur_count), 32'd0);
    endtask

    task automatic t_byte_inc_and_tc;
        page = 8'h34; hi_page = 8'h56; word_mode = 0; dec_mode = 0; auto_init = 0;
        do_load(16'hFFFE, 16'd3);
        check("R2 addr", 32'(cur_addr), 32'hFFFE);
        check("R2 count", 32'(cur_count), 32'd3);
        check("R2 masked", 32'(masked), 32'd0);
        check("R3 bus", bus_addr, 32'h5634_FFFE);
        do_steps(1);
        check("R5 addr step", 32'(cur_addr), 32'hFFFF);
        check("R7 count step", 32'(cur_count), 32'd2);
        do_steps(1);
        check("R5 wrap bus", bus_addr, 32'h5634_0000);
        do_steps(1);
        check("R7 count zero", 32'(cur_count), 32'd0);
        check("R7 no early pulse", 32'(tc_pulse), 32'd0);
        do_steps(1);
        check("R7 tc pulse", 32'(tc_pulse), 32'd1);
        check("R8 addr after tc", 32'(cur_addr), 32'h0002);
        check("R8 count after tc", 32'(cur_count), 32'hFFFF);
        check("R8 masked", 32'(masked), 32'd1);
        check("R8 tc_status", 32'(tc_status), 32'd1);
        do_steps(2);
        check("R7 pulse one cycle", 32'(tc_pulse), 32'd0);
        check("R8 frozen addr", 32'(cur_addr), 32'h0002);
        check("R8 frozen count", 32'(cur_count), 32'hFFFF);
        do_load(16'h0010, 16'd1);
        check("R2 reload clears status", 32'(tc_status), 32'd0);
    endtask

    task automatic t_decrement;
        dec_mode = 1;
        do_load(16'h0001, 16'd5);
        do_steps(1);
        check("R6 dec", 32'(cur_addr), 32'h0000);
        do_steps(1);
        check("R6 wrap", 32'(cur_addr), 32'hFFFF);
        check("R7 count", 32'(cur_count), 32'd3);
        dec_mode = 0;
    endtask

    task automatic t_word;
        word_mode = 1; page = 8'h35; hi_page = 8'h56;
        do_load(16'h8000, 16'd9);
        check("R4 word bus", bus_addr, 32'h5635_0000);
        page = 8'h34;
        #1;
        check("R4 page bit0 ignored", bus_addr, 32'h5635_0000);
        do_load(16'hFFFF, 16'd9);
        check("R4 word top", bus_addr, 32'h5635_FFFE);
        do_steps(1);
        check("R5 word wrap in 128K", bus_addr, 32'h5634_0000);
        word_mode = 0;
    endtask

    task automatic t_auto_init;
        auto_init = 1;
        do_load(16'h0100, 16'd1);
        do_steps(1);
        check("R7 ai addr", 32'(cur_addr), 32'h0101);
        do_steps(1);
        check("R9 reload addr", 32'(cur_addr), 32'h0100);
        check("R9 reload count", 32'(cur_count), 32'd1);
        check("R9 pulse", 32'(tc_pulse), 32'd1);
        check("R9 unmasked", 32'(masked), 32'd0);
        check("R9 status", 32'(tc_status), 32'd0);
        auto_init = 0;
    endtask

    task automatic t_disabled;
        do_load(16'h0200, 16'd4);
        ctrl_en = 0;
        do_steps(3);
        check("R10 addr hold", 32'(cur_addr), 32'h0200);
        check("R10 count hold", 32'(cur_count), 32'd4);
        ctrl_en = 1;
        do_steps(1);
        check("R10 resume", 32'(cur_addr), 32'h0201);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle_ignored();
        t_byte_inc_and_tc();
        t_decrement();
        t_word();
        t_auto_init();
        t_disabled();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule